// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block is the descriptor engine of a card host controller's DMA path. Software places a chain of 32-bit descriptors in system memory, programs the address of the first one, and sets the block size and block count. It then issues a data command with DMA enabled and the DMA select field set to the chained mode. The engine fetches descriptors one at a time through a simple memory read port. It collects a byte count from each set-length descriptor, and hands the data mover one segment request (page address and length) for each transfer descriptor that follows.

Link descriptors redirect the fetch pointer, and no-op descriptors are skipped. The descriptor with its end flag set closes the chain. When the chain closes, the engine compares the sum of all programmed lengths with block size times block count and pulses done. Malformed chains stop the engine with an error flag and the address of the offending descriptor.

Descriptor word layout: bit 0 valid, bit 1 end, bit 2 interrupt, bits [5:4] kind (00 no-op, 01 set-length, 10 transfer, 11 link), bits [11:6] sub-page offset (must be zero for a transfer), bits [31:12] page number (transfer and link target = page number shifted left by 12), with the set-length byte count in bits [27:12].

Top module: `sg_chain_walker`

## Requirements
- R1: A start pulse is accepted only while idle with the DMA select input equal to 2'b01 and the DMA enable input high; the first fetch then reads the programmed descriptor base address. Otherwise the engine stays idle and issues no fetch.
- R2: Unless a link is taken, the fetch pointer advances by 4 bytes after each descriptor; a no-op descriptor (kind 00) produces no segment.
- R3: A set-length descriptor (kind 01) arms the byte count in bits [27:12]; the following transfer descriptor (kind 10) raises a segment request whose address is bits [31:12] shifted left by 12 and whose length is the armed count, held stable until the data mover acknowledges.
- R4: A transfer descriptor with no armed length raises the DMA error and stops the engine.
- R5: A transfer descriptor with nonzero bits [11:6] is not page aligned; it raises the DMA error and stops the engine without a segment request.
- R6: A set-length count that is zero or not a whole multiple of the block size (or a block size of zero) raises the DMA error.
- R7: A descriptor with bit 0 clear raises the DMA error, and the error address output holds that descriptor's address.
- R8: A link descriptor (kind 11) without the end flag moves the fetch pointer to bits [31:12] shifted left by 12.
- R9: After the end-flagged descriptor completes (for a transfer, after its acknowledge), done pulses for exactly one cycle and the engine returns idle.
- R10: At chain end, if the summed set-length counts differ from block size times block count, the length error flag rises together with done.
- R11: A transfer descriptor with bit 2 set pulses the interrupt output for one cycle once its segment is acknowledged.
- R12: A DMA error stops the engine without a done pulse; both error flags and the error address clear on the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dma_sel_i | input | 2 | DMA mode select; 2'b01 selects chained mode |
| dma_en_i | input | 1 | Command DMA enable |
| start_i | input | 1 | Command issue pulse |
| desc_base_i | input | 32 | Address of the first descriptor |
| blk_size_i | input | 12 | Block size in bytes |
| blk_cnt_i | input | 16 | Number of blocks |
| mem_req_o | output | 1 | Descriptor read request, held until data returns |
| mem_addr_o | output | 32 | Descriptor read address |
| mem_rvalid_i | input | 1 | Descriptor read data valid |
| mem_rdata_i | input | 32 | Descriptor read data |
| seg_req_o | output | 1 | Segment request to the data mover |
| seg_addr_o | output | 32 | Segment start address |
| seg_len_o | output | 16 | Segment length in bytes |
| seg_done_i | input | 1 | Segment acknowledge from the data mover |
| busy_o | output | 1 | Engine active |
| done_o | output | 1 | One-cycle pulse at successful chain end |
| irq_o | output | 1 | One-cycle descriptor interrupt pulse |
| dma_err_o | output | 1 | Sticky DMA error |
| len_err_o | output | 1 | Sticky total-length mismatch |
| err_addr_o | output | 32 | Address of the descriptor that caused the DMA error |

## Verification
The walker is run over a set of chains stored in a model memory: a minimal set-length/transfer pair, an end-flagged no-op with zero blocks, a multi-group chain with a leading no-op, and a chain split by a link jump. The segment count, first segment address, summed length and interrupt count separate sequential advance from link redirection, and show whether lengths pair with the right transfer. Error chains each contain one defect: an unaligned transfer, a transfer without a length, an invalid word, a non-multiple length, or a total mismatch. The reported error address shows which descriptor the engine stopped on, and tells apart a stop from a completion that raised a flag. Directed runs check gating by select and enable and the clearing of errors at a later start.

// File: rtl/sg_walker_pkg.sv
package sg_walker_pkg;
  localparam int DESC_W   = 32;
  localparam int PAGE_SH  = 12;
  localparam int FIELD_W  = DESC_W - PAGE_SH;
  localparam int OFFS_W   = 6;

  typedef enum logic [1:0] {
    ACT_NOP    = 2'b00,
    ACT_SETLEN = 2'b01,
    ACT_XFER   = 2'b10,
    ACT_LINK   = 2'b11
  } act_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DECODE, ST_XFER, ST_CHECK
  } state_e;

  typedef struct packed {
    logic [FIELD_W-1:0] field;
    logic [OFFS_W-1:0]  offs;
    act_e               act;
    logic               rsvd;
    logic               irq;
    logic               last;
    logic               valid;
  } desc_t;
endpackage

// File: rtl/sg_desc_decode.sv
module sg_desc_decode
  import sg_walker_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic [DESC_W-1:0] word_i,
  output desc_t             desc_o,
  output logic [DESC_W-1:0] page_addr_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              misalign_o
);
  always_comb begin
    desc_o      = desc_t'(word_i);
    page_addr_o = {desc_o.field, {PAGE_SH{1'b0}}};
    len_o       = desc_o.field[LEN_W-1:0];
    misalign_o  = |desc_o.offs;
  end
endmodule

// File: rtl/sg_len_track.sv
module sg_len_track #(
  parameter int LEN_W  = 16,
  parameter int BSZ_W  = 12,
  parameter int BCNT_W = 16,
  parameter int TOT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic              consume_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [BSZ_W-1:0]  blk_size_i,
  input  logic [BCNT_W-1:0] blk_cnt_i,
  output logic              pend_o,
  output logic [LEN_W-1:0]  seg_len_o,
  output logic              len_bad_o,
  output logic              total_ok_o
);
  logic [TOT_W-1:0] total_q;
  logic [LEN_W-1:0] rem;
  logic [TOT_W-1:0] expect_tot;

  always_comb begin
    rem        = (blk_size_i == '0) ? '0 : (len_i % LEN_W'(blk_size_i));
    len_bad_o  = (blk_size_i == '0) || (len_i == '0) || (rem != '0);
    expect_tot = TOT_W'(blk_size_i) * TOT_W'(blk_cnt_i);
    total_ok_o = (total_q == expect_tot);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      total_q   <= '0;
      pend_o    <= 1'b0;
      seg_len_o <= '0;
    end else if (clear_i) begin
      total_q   <= '0;
      pend_o    <= 1'b0;
      seg_len_o <= '0;
    end else if (load_i) begin
      total_q   <= total_q + TOT_W'(len_i);
      pend_o    <= 1'b1;
      seg_len_o <= len_i;
    end else if (consume_i) begin
      pend_o    <= 1'b0;
    end
  end

  // R4
  consume_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume_i |-> pend_o);

  // R6
  load_multiple_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> pend_o && (seg_len_o != '0));
endmodule

// File: rtl/sg_chain_walker.sv
module sg_chain_walker
  import sg_walker_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int BSZ_W     = 12,
  parameter int BCNT_W    = 16,
  parameter int TOT_W     = 32,
  parameter int DESC_STEP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        dma_sel_i,
  input  logic              dma_en_i,
  input  logic              start_i,
  input  logic [DESC_W-1:0] desc_base_i,
  input  logic [BSZ_W-1:0]  blk_size_i,
  input  logic [BCNT_W-1:0] blk_cnt_i,
  output logic              mem_req_o,
  output logic [DESC_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DESC_W-1:0] mem_rdata_i,
  output logic              seg_req_o,
  output logic [DESC_W-1:0] seg_addr_o,
  output logic [LEN_W-1:0]  seg_len_o,
  input  logic              seg_done_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              irq_o,
  output logic              dma_err_o,
  output logic              len_err_o,
  output logic [DESC_W-1:0] err_addr_o
);
  localparam logic [1:0] SEL_CHAIN = 2'b01;
  localparam logic [DESC_W-1:0] STEP = DESC_W'(DESC_STEP);

  state_e            state_q;
  logic [DESC_W-1:0] ptr_q, word_q, seg_addr_q, err_addr_q;
  logic              done_q, irq_q, derr_q, lerr_q;

  desc_t             dec;
  logic [DESC_W-1:0] page_addr;
  logic [LEN_W-1:0]  dec_len;
  logic              misalign;
  logic              pend, len_bad, total_ok;
  logic              go, fault, ld_len, consume;

  sg_desc_decode #(.LEN_W(LEN_W)) i_decode (
    .word_i      (word_q),
    .desc_o      (dec),
    .page_addr_o (page_addr),
    .len_o       (dec_len),
    .misalign_o  (misalign)
  );

  always_comb begin
    go      = (state_q == ST_IDLE) && start_i && (dma_sel_i == SEL_CHAIN) && dma_en_i;
    fault   = !dec.valid
            || (dec.act == ACT_SETLEN && len_bad)
            || (dec.act == ACT_XFER && (!pend || misalign));
    ld_len  = (state_q == ST_DECODE) && !fault && (dec.act == ACT_SETLEN);
    consume = (state_q == ST_XFER) && seg_done_i;
  end

  sg_len_track #(
    .LEN_W(LEN_W), .BSZ_W(BSZ_W), .BCNT_W(BCNT_W), .TOT_W(TOT_W)
  ) i_len (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (go),
    .load_i     (ld_len),
    .consume_i  (consume),
    .len_i      (dec_len),
    .blk_size_i (blk_size_i),
    .blk_cnt_i  (blk_cnt_i),
    .pend_o     (pend),
    .seg_len_o  (seg_len_o),
    .len_bad_o  (len_bad),
    .total_ok_o (total_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      ptr_q      <= '0;
      word_q     <= '0;
      seg_addr_q <= '0;
      err_addr_q <= '0;
      done_q     <= 1'b0;
      irq_q      <= 1'b0;
      derr_q     <= 1'b0;
      lerr_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (go) begin
          ptr_q      <= desc_base_i;
          derr_q     <= 1'b0;
          lerr_q     <= 1'b0;
          err_addr_q <= '0;
          state_q    <= ST_FETCH;
        end
        ST_FETCH: if (mem_rvalid_i) begin
          word_q  <= mem_rdata_i;
          state_q <= ST_DECODE;
        end
        ST_DECODE: begin
          if (fault) begin
            derr_q     <= 1'b1;
            err_addr_q <= ptr_q;
            state_q    <= ST_IDLE;
          end else if (dec.act == ACT_XFER) begin
            seg_addr_q <= page_addr;
            state_q    <= ST_XFER;
          end else if (dec.last) begin
            state_q <= ST_CHECK;
          end else begin
            ptr_q   <= (dec.act == ACT_LINK) ? page_addr : ptr_q + STEP;
            state_q <= ST_FETCH;
          end
        end
        ST_XFER: if (seg_done_i) begin
          irq_q <= dec.irq;
          if (dec.last) state_q <= ST_CHECK;
          else begin
            ptr_q   <= ptr_q + STEP;
            state_q <= ST_FETCH;
          end
        end
        ST_CHECK: begin
          done_q  <= 1'b1;
          lerr_q  <= !total_ok;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (state_q == ST_FETCH);
  assign mem_addr_o = ptr_q;
  assign seg_req_o  = (state_q == ST_XFER);
  assign seg_addr_o = seg_addr_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign irq_o      = irq_q;
  assign dma_err_o  = derr_q;
  assign len_err_o  = lerr_q;
  assign err_addr_o = err_addr_q;

  // R1
  start_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(dma_sel_i) == SEL_CHAIN) && $past(dma_en_i));

  // R3
  seg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_req_o && !seg_done_i |=> seg_req_o && $stable(seg_addr_o) && $stable(seg_len_o));

  // R5
  seg_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_req_o |-> (seg_addr_o[PAGE_SH-1:0] == '0));

  // R4
  seg_len_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_req_o |-> (seg_len_o != '0));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  // R12
  err_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dma_err_o) |-> !done_o && !busy_o);
endmodule

// File: tb/test_sg_chain_walker.sv
module test_sg_chain_walker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  dma_sel_i = 2'b00;
  logic        dma_en_i = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] desc_base_i = '0;
  logic [11:0] blk_size_i = '0;
  logic [15:0] blk_cnt_i = '0;
  logic        mem_req_o, seg_req_o, busy_o, done_o, irq_o, dma_err_o, len_err_o;
  logic [31:0] mem_addr_o, seg_addr_o, err_addr_o;
  logic [15:0] seg_len_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        seg_done_i = 1'b0;

  always #2 clk_i = ~clk_i;

  sg_chain_walker i_sg_chain_walker (.*);

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [64];
  int nseg, sum_len, irq_cnt;
  logic [31:0] first_addr;

  function automatic logic [5:0] widx(logic [31:0] a);
    return {a[13:12], a[5:2]};
  endfunction

  // field, offset, kind, irq, end, valid
  function automatic logic [31:0] mk(logic [19:0] f, logic [5:0] o, logic [1:0] k,
                                     logic irq, logic last, logic v);
    return {f, o, k, 1'b0, irq, last, v};
  endfunction

  task automatic chk(logic ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory and data mover models
  always @(negedge clk_i) begin
    if (mem_req_o && !mem_rvalid_i) begin
      mem_rvalid_i = 1'b1;
      mem_rdata_i  = mem[widx(mem_addr_o)];
    end else mem_rvalid_i = 1'b0;
    if (seg_req_o && !seg_done_i) begin
      seg_done_i = 1'b1;
      if (nseg == 0) first_addr = seg_addr_o;
      nseg++;
      sum_len += int'(seg_len_o);
    end else seg_done_i = 1'b0;
    if (irq_o) irq_cnt++;
  end

  typedef struct packed {
    logic [31:0] base;
    logic [11:0] bsz;
    logic [15:0] bcnt;
    logic [7:0]  nseg;
    logic [15:0] sum;
    logic [31:0] addr0;
    logic [3:0]  irqs;
    logic        done;
    logic        derr;
    logic        lerr;
    logic [31:0] eaddr;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{32'h0000, 12'd512, 16'd1, 8'd1, 16'd512,  32'h10000, 4'd1, 1'b1, 1'b0, 1'b0, 32'h0},    // R3 R9 R11
    '{32'h0008, 12'd512, 16'd0, 8'd0, 16'd0,    32'h0,     4'd0, 1'b1, 1'b0, 1'b0, 32'h0},    // R2 R9 no-op end
    '{32'h0020, 12'd512, 16'd3, 8'd2, 16'd1536, 32'h20000, 4'd0, 1'b1, 1'b0, 1'b0, 32'h0},    // R2 R3
    '{32'h0034, 12'd512, 16'd2, 8'd0, 16'd0,    32'h0,     4'd0, 1'b0, 1'b1, 1'b0, 32'h34},   // R6
    '{32'h1000, 12'd256, 16'd2, 8'd1, 16'd512,  32'h30000, 4'd1, 1'b1, 1'b0, 1'b0, 32'h0},    // R8 R12
    '{32'h1020, 12'd512, 16'd2, 8'd1, 16'd512,  32'h40000, 4'd0, 1'b1, 1'b0, 1'b1, 32'h0},    // R10
    '{32'h2020, 12'd512, 16'd1, 8'd0, 16'd0,    32'h0,     4'd0, 1'b0, 1'b1, 1'b0, 32'h2024}, // R7
    '{32'h3000, 12'd512, 16'd1, 8'd0, 16'd0,    32'h0,     4'd0, 1'b0, 1'b1, 1'b0, 32'h3004}, // R5
    '{32'h3020, 12'd512, 16'd1, 8'd0, 16'd0,    32'h0,     4'd0, 1'b0, 1'b1, 1'b0, 32'h3020}  // R4
  };

  task automatic run(logic [31:0] base, logic [11:0] bsz, logic [15:0] bcnt,
                     logic [1:0] sel, logic en, output logic saw_done);
    @(negedge clk_i);
    nseg = 0; sum_len = 0; irq_cnt = 0; first_addr = '0;
    desc_base_i = base; blk_size_i = bsz; blk_cnt_i = bcnt;
    dma_sel_i = sel; dma_en_i = en; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    saw_done = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (done_o) begin saw_done = 1'b1; break; end
      if (dma_err_o || !busy_o) break;
      @(negedge clk_i);
    end
    @(negedge clk_i);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic d;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem[widx(32'h0000)] = mk(20'd512, 6'd0, 2'b01, 0, 0, 1);
    mem[widx(32'h0004)] = mk(20'h10,  6'd0, 2'b10, 1, 1, 1);
    mem[widx(32'h0008)] = mk(20'h0,   6'd0, 2'b00, 0, 1, 1);
    mem[widx(32'h0020)] = mk(20'h0,   6'd0, 2'b00, 0, 0, 1);
    mem[widx(32'h0024)] = mk(20'd1024,6'd0, 2'b01, 0, 0, 1);
    mem[widx(32'h0028)] = mk(20'h20,  6'd0, 2'b10, 0, 0, 1);
    mem[widx(32'h002C)] = mk(20'd512, 6'd0, 2'b01, 0, 0, 1);
    mem[widx(32'h0030)] = mk(20'h21,  6'd0, 2'b10, 0, 1, 1);
    mem[widx(32'h0034)] = mk(20'd768, 6'd0, 2'b01, 0, 0, 1);
    mem[widx(32'h1000)] = mk(20'd512, 6'd0, 2'b01, 0, 0, 1);
    mem[widx(32'h1004)] = mk(20'h2,   6'd0, 2'b11, 0, 0, 1);
    mem[widx(32'h2000)] = mk(20'h30,  6'd0, 2'b10, 1, 1, 1);
    mem[widx(32'h1020)] = mk(20'd512, 6'd0, 2'b01, 0, 0, 1);
    mem[widx(32'h1024)] = mk(20'h40,  6'd0, 2'b10, 0, 1, 1);
    mem[widx(32'h2020)] = mk(20'd512, 6'd0, 2'b01, 0, 0, 1);
    mem[widx(32'h2024)] = 32'h0000_0000;
    mem[widx(32'h3000)] = mk(20'd512, 6'd0, 2'b01, 0, 0, 1);
    mem[widx(32'h3004)] = mk(20'h50,  6'd1, 2'b10, 0, 1, 1);
    mem[widx(32'h3020)] = mk(20'h60,  6'd0, 2'b10, 0, 1, 1);

    repeat (3) @(negedge clk_i);
    // reset state
    chk(!busy_o && !mem_req_o && !seg_req_o, "reset busy/req", {busy_o, mem_req_o, seg_req_o}, 0);
    chk(!done_o && !dma_err_o && !len_err_o, "reset flags", {done_o, dma_err_o, len_err_o}, 0);
    rst_ni = 1'b1;

    // R1: wrong select, then enable low
    run(32'h0000, 12'd512, 16'd1, 2'b10, 1'b1, d);
    chk(!busy_o && nseg == 0 && !d, "R1 sel gate", nseg, 0);
    run(32'h0000, 12'd512, 16'd1, 2'b01, 1'b0, d);
    chk(!busy_o && nseg == 0 && !d, "R1 enable gate", nseg, 0);

    foreach (VECS[k]) begin
      vec_t v = VECS[k];
      run(v.base, v.bsz, v.bcnt, 2'b01, 1'b1, d);
      chk(d == v.done, $sformatf("R9 done vec%0d", k), d, v.done);
      chk(nseg == int'(v.nseg), $sformatf("R3 segs vec%0d", k), nseg, v.nseg);
      chk(sum_len == int'(v.sum), $sformatf("R3 len sum vec%0d", k), sum_len, v.sum);
      chk(first_addr == v.addr0, $sformatf("R8 first addr vec%0d", k), first_addr, v.addr0);
      chk(irq_cnt == int'(v.irqs), $sformatf("R11 irq vec%0d", k), irq_cnt, v.irqs);
      chk(dma_err_o == v.derr, $sformatf("R12 dma err vec%0d", k), dma_err_o, v.derr);
      chk(len_err_o == v.lerr, $sformatf("R10 len err vec%0d", k), len_err_o, v.lerr);
      if (v.derr) chk(err_addr_o == v.eaddr, $sformatf("R7 err addr vec%0d", k), err_addr_o, v.eaddr);
      chk(!busy_o, $sformatf("R9 idle vec%0d", k), busy_o, 0);
    end

    // R12: errors clear on a later accepted start
    run(32'h0000, 12'd512, 16'd1, 2'b01, 1'b1, d);
    chk(d && !dma_err_o && err_addr_o == 0, "R12 clear on start", {dma_err_o, err_addr_o[7:0]}, 0);
    // R6: zero block size rejects set-length
    run(32'h0000, 12'd0, 16'd1, 2'b01, 1'b1, d);
    chk(dma_err_o && err_addr_o == 32'h0, "R6 zero block size", dma_err_o, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule